// File: doc/BRIEF.md
# Infrared Link FIFO Pair Controller

This block holds the byte buffering for a serial infrared link: one transmit queue and one receive queue, each with push and pop ports, plus a single 16-bit control word on a small register bus. The control word sets how many bytes each queue may hold (32 or 64) and holds a two-bit threshold code per direction. From that code, the queue capacity and the direction, the block derives the byte count at which it raises a service request. The receive request tracks filled bytes. The transmit request tracks free space.

The low three bits of the control word are one-shot triggers. Two of them flush a queue. The third aborts transmission: it flushes the transmit queue and emits a one-cycle stop pulse for the framing logic. Framing, abort content, DMA and interrupt handling are left to neighbouring blocks, which use the level, full, empty, overflow and request outputs.

Top module: `irfifo_ctrl`

## Requirements
- R1: After synchronous reset, both levels are 0, both queues report empty and not full, both overflow flags are 0, tx_stop is 0, rx_req is 0, tx_req is 1, and the control word reads 0x0000 (capacity 32, both thresholds 1 byte).
- R2: The control word sits at address 0 and returns on reg_rdata one cycle after the address is presented. Bits 7:6 (receive code), 5:4 (transmit code) and 3 (capacity, 1 = 64 bytes) read back as written. Bits 15:8 and 2:0 always read 0. Any other address reads 0, and writes to it have no effect.
- R3: Each queue returns bytes in push order. The popped byte appears on the queue's read-data port in the cycle after the pop edge, and the level counts accepted pushes minus accepted pops.
- R4: A queue is full when its level equals the selected capacity (32 or 64). A push while full is dropped and sets that queue's overflow flag, which stays set until that queue is flushed.
- R5: A pop from an empty queue leaves the level at 0 and holds the read-data port at the last popped byte.
- R6: rx_req is 1 exactly while the receive level is at least the receive threshold. With capacity 32, codes 0..3 give 1, 4, 16 and 26 bytes. With capacity 64, they give 1, 8, 32 and 48 bytes.
- R7: tx_req is 1 exactly while the free space (capacity minus transmit level) is at least the transmit threshold. With capacity 32, codes 0..3 give 1, 8, 16 and 26 bytes. With capacity 64, they give 1, 16, 32 and 48 bytes.
- R8: Writing 1 to bit 2 empties the transmit queue and clears its overflow flag, leaving the receive queue untouched. Writing 1 to bit 1 does the same for the receive queue only.
- R9: Writing 1 to bit 0 flushes the transmit queue and drives tx_stop high for exactly the one cycle after the write edge.
- R10: A write that changes bit 3 flushes both queues. A write that keeps bit 3 unchanged flushes neither.
- R11: A flush takes priority over a push or pop to the same queue in the same cycle: the queue ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| tx_level | output | 7 | Bytes held in the transmit queue |
| rx_level | output | 7 | Bytes held in the receive queue |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_req | output | 1 | Transmit free space at or above threshold |
| rx_req | output | 1 | Receive level at or above threshold |
| tx_stop | output | 1 | One-cycle transmission stop pulse |

## Verification
The bench walks all eight capacity and code pairings. For each, it measures the exact push count at which rx_req rises and tx_req falls. A swapped receive/transmit table, or a table that ignores the capacity bit, shifts one of those counts. It fills a queue past both 32 and 64 bytes: a pointer that wraps at the wrong limit, or a missing drop, shows up as a wrong level or a lost overflow flag. It also covers a pop from an empty queue, a flush that coincides with a push, a rewrite of an unchanged capacity bit, and the stop trigger. A design that let the push win, flushed on every write, or stretched the stop pulse would fail those checks.

// File: rtl/irfifo_pkg.sv
package irfifo_pkg;

  localparam int unsigned LVL_W = 7;

  typedef logic [LVL_W-1:0] level_t;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       big;
  } cfg_t;

  // Byte count represented by a threshold code for one direction.
  function automatic level_t thr_bytes(input logic is_tx, input logic big,
                                       input logic [1:0] code);
    level_t v;
    case (code)
      2'd0:    v = level_t'(1);
      2'd1:    v = big ? (is_tx ? level_t'(16) : level_t'(8))
                       : (is_tx ? level_t'(8)  : level_t'(4));
      2'd2:    v = big ? level_t'(32) : level_t'(16);
      default: v = big ? level_t'(48) : level_t'(26);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/irfifo_regs.sv
module irfifo_regs
  import irfifo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output cfg_t              cfg,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              stop_pulse
);

  localparam int unsigned PAD_W = REG_W - 8;

  cfg_t cfg_q;
  logic hit;
  logic wr_hit;
  logic cap_chg;
  logic stop_now;

  assign hit      = (addr == ADDR_W'(REG_ADDR));
  assign wr_hit   = we & hit;
  assign cap_chg  = wr_hit & (wdata[3] != cfg_q.big);
  assign stop_now = wr_hit & wdata[0];

  assign tx_flush = (wr_hit & wdata[2]) | stop_now | cap_chg;
  assign rx_flush = (wr_hit & wdata[1]) | cap_chg;
  assign cfg      = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      rdata      <= '0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= stop_now;
      if (wr_hit) begin
        cfg_q.rx_code <= wdata[7:6];
        cfg_q.tx_code <= wdata[5:4];
        cfg_q.big     <= wdata[3];
      end
      rdata <= hit ? {{PAD_W{1'b0}}, cfg_q.rx_code, cfg_q.tx_code, cfg_q.big, 3'b000}
                   : '0;
    end
  end

endmodule

// File: rtl/irfifo_buf.sv
module irfifo_buf
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEPTH_MAX = 64,
  parameter int unsigned LVL_W     = $clog2(DEPTH_MAX) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              big,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              ovf
);

  localparam int unsigned PTR_W     = $clog2(DEPTH_MAX);
  localparam int unsigned DEPTH_MIN = DEPTH_MAX / 2;

  logic [DATA_W-1:0] mem [DEPTH_MAX];
  logic [PTR_W-1:0]  wp, rp, last_idx;
  logic [LVL_W-1:0]  limit, cnt;
  logic              do_push, do_pop;

  assign limit    = big ? LVL_W'(DEPTH_MAX) : LVL_W'(DEPTH_MIN);
  assign last_idx = big ? PTR_W'(DEPTH_MAX - 1) : PTR_W'(DEPTH_MIN - 1);
  assign full     = (cnt == limit);
  assign empty    = (cnt == '0);
  assign level    = cnt;
  assign do_push  = push & ~full  & ~flush;
  assign do_pop   = pop  & ~empty & ~flush;

  // Storage: single write port, registered read, no reset.
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == last_idx) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == last_idx) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/irfifo_mark.sv
module irfifo_mark
  import irfifo_pkg::*;
#(
  parameter int unsigned DEPTH_MAX = 64
) (
  input  cfg_t   cfg,
  input  level_t rx_level,
  input  level_t tx_level,
  output logic   rx_req,
  output logic   tx_req
);

  level_t limit, tx_free, rx_th, tx_th;

  assign limit   = cfg.big ? level_t'(DEPTH_MAX) : level_t'(DEPTH_MAX / 2);
  assign tx_free = limit - tx_level;
  assign rx_th   = thr_bytes(1'b0, cfg.big, cfg.rx_code);
  assign tx_th   = thr_bytes(1'b1, cfg.big, cfg.tx_code);
  assign rx_req  = (rx_level >= rx_th);
  assign tx_req  = (tx_free  >= tx_th);

endmodule

// File: rtl/irfifo_ctrl.sv
module irfifo_ctrl
  import irfifo_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEPTH_MAX = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              tx_ovf,
  output logic              rx_ovf,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_stop
);

  cfg_t cfg;
  logic tx_flush, rx_flush;
  logic cap_big;

  assign cap_big = cfg.big;

  irfifo_regs #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .REG_ADDR(0)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg(cfg), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .stop_pulse(tx_stop)
  );

  irfifo_buf #(
    .DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .LVL_W(LVL_W)
  ) txq_i (
    .clk(clk), .rst(rst), .flush(tx_flush), .big(cap_big),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .level(tx_level), .full(tx_full), .empty(tx_empty), .ovf(tx_ovf)
  );

  irfifo_buf #(
    .DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .LVL_W(LVL_W)
  ) rxq_i (
    .clk(clk), .rst(rst), .flush(rx_flush), .big(cap_big),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty), .ovf(rx_ovf)
  );

  irfifo_mark #(
    .DEPTH_MAX(DEPTH_MAX)
  ) mark_i (
    .cfg(cfg), .rx_level(rx_level), .tx_level(tx_level),
    .rx_req(rx_req), .tx_req(tx_req)
  );

endmodule

// File: rtl/irfifo_ctrl_chk.sv
module irfifo_ctrl_chk
#(
  parameter int unsigned DEPTH_MAX = 64,
  parameter int unsigned LVL_W     = 7,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned DATA_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              tx_push,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              rx_pop,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              tx_full,
  input logic              rx_empty,
  input logic              tx_ovf,
  input logic [DATA_W-1:0] rx_rdata,
  input logic              rx_req,
  input logic              tx_stop,
  input logic              cap_big
);

  // R2: reserved and trigger bits never read as 1
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[REG_W-1:8] == '0) && (reg_rdata[2:0] == 3'b000));

  // R4: level never exceeds the selected capacity
  p_level_cap_r4: assert property (@(posedge clk) disable iff (rst)
    tx_level <= (cap_big ? LVL_W'(DEPTH_MAX) : LVL_W'(DEPTH_MAX / 2)));

  // R4: push into a full queue is dropped and flagged
  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_push && !tx_pop && !reg_we) |=> (tx_ovf && $stable(tx_level)));

  // R4: overflow is sticky without a register write
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_ovf && !reg_we) |=> tx_ovf);

  // R5: pop from empty leaves read data unchanged
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && rx_pop && !rx_push) |=> ($stable(rx_rdata) && rx_level == '0));

  // R6: no receive request with an empty queue
  p_rx_req_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |-> !rx_req);

  // R9: stop pulse lasts a single cycle
  p_stop_single_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_stop && !reg_we) |=> !tx_stop);

  // R9: transmit queue is empty while the stop pulse is high
  p_stop_flush_r9: assert property (@(posedge clk) disable iff (rst)
    tx_stop |-> (tx_level == '0));

endmodule

bind irfifo_ctrl irfifo_ctrl_chk #(
  .DEPTH_MAX(DEPTH_MAX), .LVL_W(irfifo_pkg::LVL_W), .REG_W(REG_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
  .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full),
  .rx_empty(rx_empty), .tx_ovf(tx_ovf), .rx_rdata(rx_rdata),
  .rx_req(rx_req), .tx_stop(tx_stop), .cap_big(cap_big)
);

// File: tb/irfifo_ctrl_tb_top.sv
module irfifo_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0]  tx_wdata = '0, rx_wdata = '0;
  logic [7:0]  tx_rdata, rx_rdata;
  logic [6:0]  tx_level, rx_level;
  logic        tx_full, tx_empty, rx_full, rx_empty, tx_ovf, rx_ovf;
  logic        tx_req, rx_req, tx_stop;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irfifo_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
    .tx_req(tx_req), .rx_req(rx_req), .tx_stop(tx_stop)
  );

  // Entry layout: {pad, capacity bit, code, rx threshold, tx threshold}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 6'd1,  6'd1},
    {1'b0, 1'b0, 2'd1, 6'd4,  6'd8},
    {1'b0, 1'b0, 2'd2, 6'd16, 6'd16},
    {1'b0, 1'b0, 2'd3, 6'd26, 6'd26},
    {1'b0, 1'b1, 2'd0, 6'd1,  6'd1},
    {1'b0, 1'b1, 2'd1, 6'd8,  6'd16},
    {1'b0, 1'b1, 2'd2, 6'd32, 6'd32},
    {1'b0, 1'b1, 2'd3, 6'd48, 6'd48}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_addr = a;
    step();
    v = int'(reg_rdata);
    reg_addr = '0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_push = 1'b1; tx_wdata = b; step(); tx_push = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_push = 1'b1; rx_wdata = b; step(); rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
  endtask

  task automatic pop_rx();
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, n, lim, cap, code, rxe, txe;
    step(); step();
    rst = 1'b0;
    step();

    // R1: reset state
    rd(4'd0, v);
    chk("R1 rdata", v, 0);
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 empty", int'({tx_empty, rx_empty, tx_full, rx_full}), 4'b1100);
    chk("R1 ovf", int'({tx_ovf, rx_ovf, tx_stop}), 0);
    chk("R1 req", int'({rx_req, tx_req}), 2'b01);

    // R6/R7 table walk: push count at which each request changes
    for (int i = 0; i < 8; i++) begin
      cap  = int'(VEC[i][14]);
      code = int'(VEC[i][13:12]);
      rxe  = int'(VEC[i][11:6]);
      txe  = int'(VEC[i][5:0]);
      lim  = cap ? 64 : 32;
      wr(4'd0, 16'((code << 6) | (code << 4) | (cap << 3) | 6));
      rd(4'd0, v);
      chk("R2 readback", v, (code << 6) | (code << 4) | (cap << 3));
      n = 0;
      while (!rx_req && n < 70) begin push_rx(8'(n)); n++; end
      chk("R6 rx threshold", n, rxe);
      n = 0;
      while (tx_req && n < 70) begin push_tx(8'(n)); n++; end
      chk("R7 tx threshold", n, lim - txe + 1);
    end

    // R2: reserved bits and foreign address
    wr(4'd0, 16'hFFFF);
    rd(4'd0, v);
    chk("R2 reserved", v, 16'h00F8);
    wr(4'd3, 16'h0000);
    rd(4'd0, v);
    chk("R2 other addr write", v, 16'h00F8);
    rd(4'd3, v);
    chk("R2 other addr read", v, 0);
    wr(4'd0, 16'h0006);

    // R3: ordering and level
    for (int k = 0; k < 5; k++) push_tx(8'(8'h11 * (k + 1)));
    chk("R3 level", int'(tx_level), 5);
    for (int k = 0; k < 5; k++) begin
      pop_tx();
      chk("R3 order", int'(tx_rdata), 8'h11 * (k + 1));
    end
    chk("R3 empty", int'(tx_empty), 1);

    // R4: capacity 32 overflow
    for (int k = 0; k < 34; k++) push_rx(8'(k));
    chk("R4 level32", int'(rx_level), 32);
    chk("R4 full32", int'({rx_full, rx_ovf}), 2'b11);
    pop_rx();
    chk("R4 ovf sticky", int'(rx_ovf), 1);
    chk("R4 first byte kept", int'(rx_rdata), 0);
    // R4: capacity 64 (change flushes)
    wr(4'd0, 16'h0008);
    for (int k = 0; k < 66; k++) push_rx(8'(k + 100));
    chk("R4 level64", int'(rx_level), 64);
    chk("R4 full64", int'({rx_full, rx_ovf}), 2'b11);
    for (int k = 0; k < 64; k++) pop_rx();
    chk("R4 wrap last byte", int'(rx_rdata), 163);

    // R5: pop when empty
    pop_rx();
    chk("R5 data held", int'(rx_rdata), 163);
    chk("R5 level", int'(rx_level), 0);

    // R8: independent flushes
    wr(4'd0, 16'h0000);
    for (int k = 0; k < 3; k++) begin push_tx(8'(k)); push_rx(8'(k)); end
    wr(4'd0, 16'h0004);
    chk("R8 tx flushed", int'(tx_level), 0);
    chk("R8 rx kept", int'(rx_level), 3);
    wr(4'd0, 16'h0002);
    chk("R8 rx flushed", int'(rx_level), 0);

    // R10: same capacity keeps data, changed capacity flushes
    for (int k = 0; k < 3; k++) push_rx(8'(k));
    wr(4'd0, 16'h0000);
    chk("R10 same cap", int'(rx_level), 3);
    push_tx(8'h5A);
    wr(4'd0, 16'h0008);
    chk("R10 cap change", int'({rx_level, tx_level}), 0);

    // R9: stop trigger
    for (int k = 0; k < 3; k++) push_tx(8'(k));
    wr(4'd0, 16'h0009);
    chk("R9 stop pulse", int'(tx_stop), 1);
    chk("R9 tx flushed", int'(tx_level), 0);
    step();
    chk("R9 pulse width", int'(tx_stop), 0);

    // R11: flush wins over a simultaneous push
    push_rx(8'h33);
    rx_push = 1'b1; rx_wdata = 8'h44;
    wr(4'd0, 16'h000A);
    rx_push = 1'b0;
    chk("R11 flush priority", int'(rx_level), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule